// File: doc/BRIEF.md
# Watchdog Counter with Reset or NMI Response

This block is a supervisory timer for a small processor system. An 8-bit counter advances on a tick taken from a selectable divider of the system clock. It advances only while the control register has both its watchdog-mode bit and its run bit set. Firmware has to rewrite the counter, usually with zero, often enough that it never wraps past its top value. If it does wrap, the block raises an overflow flag and responds in one of two ways, chosen by a control bit. It either asserts an internal reset output for a fixed 518 system clocks, or it gives a one-cycle non-maskable interrupt request.

The register interface is a two-word space written through a one-cycle write strobe and read combinationally. A reset-source flag tells firmware whether the last reset came from the external pin or from the watchdog. When both happen in the same cycle, the pin takes precedence. While the internal reset pulse runs, the counter, the control register and the divider are held cleared and ignore writes.

Top module: `wdog_top`

## Requirements
- R1: The counter advances only while control bit 6 (watchdog mode) and control bit 5 (run) are both 1; with either at 0 it holds its value.
- R2: Control bits 2:0 select the tick period in system clocks: 0→2, 1→64, 2→128, 3→512, 4→2048, 5→8192, 6→32768, 7→131072. The counter advances once per period, first at the end of the first full period after the run condition takes effect.
- R3: A tick at count 0xFF wraps the counter to 0x00 and sets control bit 7 (overflow). Writing 0 to bit 7 clears the flag, and writing 1 leaves it unchanged.
- R4: A counter write in the same cycle as a pending wrap loads the written value and suppresses the wrap: no flag, no reset, no interrupt.
- R5: With control bit 4 (response select) at 1, a wrap drives `wdt_reset` high from the next cycle for exactly 518 consecutive cycles.
- R6: The internal reset clears the overflow flag it caused. The flag reads 1 only in the first pulse cycle. For the rest of the pulse the counter, control register and divider stay cleared and writes have no effect.
- R7: With control bit 4 at 0, a wrap gives `nmi_req` high for exactly one cycle, and the counter keeps counting from 0x00.
- R8: `pin_reset_flag` is 1 after an external pin reset and 0 after a watchdog internal reset.
- R9: If `pin_rst` is high in the cycle a reset-mode wrap would occur, the pin reset wins: `pin_reset_flag` is 1 and no internal reset pulse starts.
- R10: Address 0 reads and writes the counter. Address 1 reads {overflow, mode, run, select, 0, divider[2:0]} from bit 7 down to bit 0. After a pin reset both read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pin_rst | input | 1 | External reset pin, synchronous, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 counter, 1 control |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for the addressed register |
| wdt_reset | output | 1 | Internal reset output from a watchdog wrap |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| pin_reset_flag | output | 1 | Reset source: 1 pin, 0 watchdog |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and the 518-cycle pulse. With those values, a full reset pulse and the divide-by-2, 64 and 128 settings all fit within a short run. Preloading the counter to 0xFC before enabling it brings each wrap to a known cycle. That lets the bench land a counter write or a pin reset on the exact cycle of the wrap, and check the first and last pulse cycles edge for edge.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Widest divider exponent (divide by 2**17)
    localparam int unsigned PS_W = 17;

    typedef enum logic {
        ADDR_COUNT = 1'b0,
        ADDR_CTRL  = 1'b1
    } wdg_addr_e;

    typedef struct packed {
        logic       ovf;      // bit 7
        logic       wd_mode;  // bit 6
        logic       run;      // bit 5
        logic       rst_sel;  // bit 4: 1 reset, 0 NMI
        logic [2:0] ps_sel;   // bits 2:0
    } wdg_ctrl_t;

    // Divider exponent for each select code
    function automatic int unsigned ps_shift(input logic [2:0] sel);
        case (sel)
            3'd0:    return 1;
            3'd1:    return 6;
            3'd2:    return 7;
            3'd3:    return 9;
            3'd4:    return 11;
            3'd5:    return 13;
            3'd6:    return 15;
            default: return 17;
        endcase
    endfunction

    function automatic logic [7:0] pack_ctrl(input wdg_ctrl_t c);
        return {c.ovf, c.wd_mode, c.run, c.rst_sel, 1'b0, c.ps_sel};
    endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
    import wdg_pkg::*;
#(
    parameter int unsigned DIV_W = PS_W
) (
    input  logic       clk,
    input  logic       clear,
    input  logic       enable,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;
    int unsigned      shift;

    always_comb begin
        shift = ps_shift(sel);
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(shift));
        end
    end

    assign tick = enable && ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (clear || !enable) div_q <= '0;
        else                  div_q <= div_q + 1'b1;
    end

    // R2: a tick never comes from a cleared divider
    p_tick_after_count_r2: assert property (@(posedge clk) disable iff (clear)
        (enable && div_q == '0) |-> !tick);
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
    parameter int unsigned LEN = 518,
    localparam int unsigned LW = $clog2(LEN)
) (
    input  logic clk,
    input  logic pin_rst,
    input  logic start,
    output logic active
);
    logic [LW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (pin_rst) begin
            active <= 1'b0;
            left_q <= '0;
        end else if (start && !active) begin
            active <= 1'b1;
            left_q <= LW'(LEN - 1);
        end else if (active) begin
            if (left_q == '0) active <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end

    // R5: pulse continues while cycles remain, ends only at zero
    p_pulse_hold_r5: assert property (@(posedge clk) disable iff (pin_rst)
        (active && left_q != '0) |=> active);
    p_pulse_end_r5: assert property (@(posedge clk) disable iff (pin_rst)
        $fell(active) |-> $past(left_q) == '0);
endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             pin_rst,
    input  logic             hold,
    input  logic             tick,
    input  logic             wr,
    input  wdg_addr_e        addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output wdg_ctrl_t        ctrl,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic cnt_wr, ctrl_wr;

    assign cnt_wr  = wr && addr == ADDR_COUNT && !hold;
    assign ctrl_wr = wr && addr == ADDR_CTRL  && !hold;
    assign wrap    = tick && count == CNT_MAX && !cnt_wr && !hold;

    always_ff @(posedge clk) begin
        if (pin_rst || hold) begin
            count <= '0;
            ctrl  <= '0;
        end else begin
            if (cnt_wr)    count <= wdata;
            else if (tick) count <= count + 1'b1;

            if (ctrl_wr) begin
                ctrl.ovf     <= ctrl.ovf & wdata[7];
                ctrl.wd_mode <= wdata[6];
                ctrl.run     <= wdata[5];
                ctrl.rst_sel <= wdata[4];
                ctrl.ps_sel  <= wdata[2:0];
            end
            if (wrap) ctrl.ovf <= 1'b1;
        end
    end

    // R6: held state is cleared on the following cycle
    p_hold_clear_r6: assert property (@(posedge clk) disable iff (pin_rst)
        hold |=> (count == '0 && ctrl == '0));
    // R3: the flag only rises from a wrap
    p_ovf_source_r3: assert property (@(posedge clk) disable iff (pin_rst)
        $rose(ctrl.ovf) |-> ($past(tick) && count == '0));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdg_pkg::*;
#(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned PULSE_LEN = 518
) (
    input  logic             clk,
    input  logic             pin_rst,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             wdt_reset,
    output logic             nmi_req,
    output logic             pin_reset_flag
);
    wdg_ctrl_t        ctrl;
    logic [CNT_W-1:0] count;
    logic             tick, wrap, pulse_start;
    wdg_addr_e        addr;

    assign addr        = wdg_addr_e'(reg_addr);
    assign pulse_start = wrap && ctrl.rst_sel;

    wdg_prescaler #(.DIV_W(PS_W)) u_div (
        .clk    (clk),
        .clear  (pin_rst || wdt_reset),
        .enable (ctrl.wd_mode && ctrl.run),
        .sel    (ctrl.ps_sel),
        .tick   (tick)
    );

    wdg_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .pin_rst(pin_rst),
        .hold   (wdt_reset),
        .tick   (tick),
        .wr     (reg_wr),
        .addr   (addr),
        .wdata  (reg_wdata),
        .count  (count),
        .ctrl   (ctrl),
        .wrap   (wrap)
    );

    wdg_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk    (clk),
        .pin_rst(pin_rst),
        .start  (pulse_start),
        .active (wdt_reset)
    );

    always_ff @(posedge clk) begin
        if (pin_rst) begin
            nmi_req        <= 1'b0;
            pin_reset_flag <= 1'b1;
        end else begin
            nmi_req <= wrap && !ctrl.rst_sel;
            if (pulse_start) pin_reset_flag <= 1'b0;
        end
    end

    always_comb begin
        if (addr == ADDR_COUNT) reg_rdata = count;
        else                    reg_rdata = CNT_W'(pack_ctrl(ctrl));
    end

    // R7: interrupt request lasts one cycle
    p_nmi_single_r7: assert property (@(posedge clk) disable iff (pin_rst)
        nmi_req |=> !nmi_req);
    // R7: interrupt and internal reset never coincide
    p_nmi_no_reset_r7: assert property (@(posedge clk) disable iff (pin_rst)
        nmi_req |-> !wdt_reset);
    // R4: a counter write blocks any response in the next cycle
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (pin_rst)
        (reg_wr && reg_addr == 1'b0 && !wdt_reset) |=> (!nmi_req && !wdt_reset));
    // R9: after a pin reset the source flag is 1 and no pulse runs
    p_pin_wins_r9: assert property (@(posedge clk) disable iff (pin_rst)
        $past(pin_rst) |-> (pin_reset_flag && !wdt_reset));
endmodule

// File: tb/test_wdog_top.sv
module test_wdog_top;
    logic       clk = 1'b0;
    logic       pin_rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       wdt_reset, nmi_req, pin_reset_flag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    wdog_top i_wdog_top (
        .clk           (clk),
        .pin_rst       (pin_rst),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .wdt_reset     (wdt_reset),
        .nmi_req       (nmi_req),
        .pin_reset_flag(pin_reset_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // All tasks are entered and left just after a falling edge.
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output int v);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic do_reset();
        pin_rst = 1'b1;
        wait_n(3);
        pin_rst = 1'b0;
    endtask

    task automatic t_reset_state();
        int v;
        do_reset();
        rd(1'b0, v); chk("R10 counter after reset", v, 0);
        rd(1'b1, v); chk("R10 control after reset", v, 0);
        chk("R8 flag after pin reset", int'(pin_reset_flag), 1);
        chk("R5 no pulse after reset", int'(wdt_reset), 0);
        chk("R7 no nmi after reset", int'(nmi_req), 0);
    endtask

    task automatic t_gating();
        int v;
        do_reset();
        wr(1'b1, 8'h40); wait_n(10);
        rd(1'b0, v); chk("R1 mode only, no count", v, 0);
        wr(1'b1, 8'h20); wait_n(10);
        rd(1'b0, v); chk("R1 run only, no count", v, 0);
        wr(1'b1, 8'h60); wait_n(20);
        rd(1'b0, v); chk("R1 both set, counts by 2", v, 10);
        rd(1'b1, v); chk("R10 control readback", v, 8'h60);
    endtask

    task automatic t_prescale();
        int v;
        do_reset();
        wr(1'b1, 8'h61); wait_n(63);
        rd(1'b0, v); chk("R2 div64 before tick", v, 0);
        wait_n(1);
        rd(1'b0, v); chk("R2 div64 first tick", v, 1);
        wait_n(64);
        rd(1'b0, v); chk("R2 div64 second tick", v, 2);
        do_reset();
        wr(1'b1, 8'h62); wait_n(127);
        rd(1'b0, v); chk("R2 div128 before tick", v, 0);
        wait_n(1);
        rd(1'b0, v); chk("R2 div128 first tick", v, 1);
    endtask

    task automatic t_nmi();
        int v;
        do_reset();
        wr(1'b0, 8'hFC);
        wr(1'b1, 8'h60); wait_n(7);
        rd(1'b0, v); chk("R3 count at top", v, 8'hFF);
        chk("R7 no nmi before wrap", int'(nmi_req), 0);
        wait_n(1);
        chk("R7 nmi on wrap", int'(nmi_req), 1);
        rd(1'b0, v); chk("R3 wrap to zero", v, 0);
        rd(1'b1, v); chk("R3 overflow flag set", v, 8'hE0);
        wait_n(1);
        chk("R7 nmi one cycle", int'(nmi_req), 0);
        wait_n(1);
        rd(1'b0, v); chk("R7 keeps counting", v, 1);
        chk("R7 no internal reset", int'(wdt_reset), 0);
        wr(1'b1, 8'hE0);
        rd(1'b1, v); chk("R3 writing 1 keeps flag", v, 8'hE0);
        wr(1'b1, 8'h60);
        rd(1'b1, v); chk("R3 writing 0 clears flag", v, 8'h60);
    endtask

    task automatic t_suppress();
        int v;
        do_reset();
        wr(1'b0, 8'hFC);
        wr(1'b1, 8'h70); wait_n(7);
        wr(1'b0, 8'h00);
        chk("R4 no reset on written wrap", int'(wdt_reset), 0);
        rd(1'b1, v); chk("R4 no flag on written wrap", v, 8'h70);
        rd(1'b0, v); chk("R4 written value loaded", v, 0);
        chk("R4 no nmi", int'(nmi_req), 0);
    endtask

    task automatic t_reset_pulse();
        int v;
        do_reset();
        wr(1'b0, 8'hFC);
        wr(1'b1, 8'h70); wait_n(7);
        chk("R5 low before wrap", int'(wdt_reset), 0);
        wait_n(1);
        chk("R5 pulse starts", int'(wdt_reset), 1);
        rd(1'b1, v); chk("R6 flag in first pulse cycle", v, 8'hF0);
        chk("R8 flag after watchdog reset", int'(pin_reset_flag), 0);
        wait_n(1);
        rd(1'b1, v); chk("R6 flag cleared by pulse", v, 0);
        wr(1'b1, 8'h60);
        wr(1'b0, 8'h55);
        rd(1'b0, v); chk("R6 counter write ignored", v, 0);
        rd(1'b1, v); chk("R6 control write ignored", v, 0);
        wait_n(514);
        chk("R5 high at cycle 518", int'(wdt_reset), 1);
        wait_n(1);
        chk("R5 low after 518", int'(wdt_reset), 0);
        chk("R8 flag stays 0", int'(pin_reset_flag), 0);
    endtask

    task automatic t_priority();
        int v;
        wr(1'b0, 8'hFC);
        wr(1'b1, 8'h70); wait_n(7);
        pin_rst = 1'b1;
        wait_n(1);
        pin_rst = 1'b0;
        chk("R9 pin reset wins, no pulse", int'(wdt_reset), 0);
        chk("R9 flag set by pin", int'(pin_reset_flag), 1);
        rd(1'b1, v); chk("R9 control cleared", v, 0);
        wait_n(1);
        chk("R9 no late pulse", int'(wdt_reset), 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        wait_n(1);
        t_reset_state();
        t_gating();
        t_prescale();
        t_nmi();
        t_suppress();
        t_reset_pulse();
        t_priority();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end
endmodule